// File: doc/BRIEF.md
# Banked interrupt-control register access resolver

This block takes one system-register access aimed at a banked interrupt-control register (the one that sets where the priority field splits for group-1 preemption) and turns the processor's current context into a single verdict. The verdict says whether the access is refused as an undefined instruction, diverted to a hypervisor-level trap, diverted to a top-level trap, steered to the virtual copy, or allowed to reach one of the stored copies: the only copy when no top level exists, or the secure or non-secure copy.

It is purely combinational. The register storage and the trap machinery sit outside; they consume the one-hot verdict, the trap target level, the syndrome code and the read/write strobes. Reads and writes go through the same decision chain, so the caller only has to present `is_write_i` to get the matching strobe. The ports are plain control pins: no data moves through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `sysreg_perm_dec`

## Requirements
- R1: `outcome_o` is one-hot in every input state, with bit 0 = undefined, bit 1 = trap to level 2, bit 2 = trap to level 3, bit 3 = virtual copy, bit 4 = single copy, bit 5 = non-secure copy, bit 6 = secure copy.
- R2: When `gic_present_i` is 0, or `lvl_i` is 0, the outcome is undefined.
- R3: At level 1 the first matching rule wins: IRQ routing with undefined-priority gives undefined; coprocessor trap gives trap to level 2; `sre_l1_i` = 0 gives undefined; trap-all-group-1 gives trap to level 2; virtual routing gives the virtual copy; IRQ routing gives trap to level 3 (undefined if `undef_not_trap_i`); otherwise non-secure copy if level 3 exists, else single copy.
- R4: At level 1, when `lvl3_aa32_i` and `mon_mode_i` are both 1, the IRQ-routing rules of R3 are skipped.
- R5: At level 2 the first matching rule wins: IRQ routing with undefined-priority gives undefined; `sre_l2_i` = 0 gives undefined; IRQ routing gives trap to level 3 (undefined if `undef_not_trap_i`); otherwise non-secure copy if level 3 exists, else single copy.
- R6: At level 3, `sre_l3_i` = 0 gives undefined; otherwise `eff_ns_i` = 0 selects the secure copy and 1 the non-secure copy.
- R7: A level-2 trap drives `tgt_lvl_o` = 2 and `synd_o` = 0x03; a level-3 trap drives `tgt_lvl_o` = 3 and `synd_o` = 0; every other outcome drives both to 0.
- R8: `is_write_i` never changes `outcome_o`; on an access to any copy (bits 3 to 6) `xfer_wr_o` follows `is_write_i` and `xfer_rd_o` its inverse, and both are 0 on undefined or trap outcomes.
- R9: Coprocessor trap, trap-all-group-1 and virtual routing take effect only when `has_lvl2_i` and `lvl2_en_i` are both 1; IRQ routing and undefined-priority take effect only when `has_lvl3_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lvl_i | input | 2 | Current privilege level, 0 to 3 |
| mon_mode_i | input | 1 | Processor is in monitor mode |
| gic_present_i | input | 1 | Interrupt interface feature present |
| has_lvl2_i | input | 1 | Level 2 implemented |
| has_lvl3_i | input | 1 | Level 3 implemented |
| lvl3_aa32_i | input | 1 | Level 3 runs in the 32-bit execution state |
| lvl2_en_i | input | 1 | Level 2 enabled in the current security state |
| cp_trap_i | input | 1 | Coprocessor register trap bit |
| trap_all_g1_i | input | 1 | Trap all group-1 accesses bit |
| virt_route_i | input | 1 | Route to virtual interface bit |
| irq_route_i | input | 1 | IRQ routed to level 3 bit |
| undef_prio_i | input | 1 | Undefined takes priority over routing |
| undef_not_trap_i | input | 1 | Raise undefined instead of a level-3 trap |
| sre_l1_i | input | 1 | Register interface enable for level 1 |
| sre_l2_i | input | 1 | Register interface enable for level 2 |
| sre_l3_i | input | 1 | Register interface enable for level 3 |
| eff_ns_i | input | 1 | Effective non-secure state bit |
| is_write_i | input | 1 | 1 for a write, 0 for a read |
| outcome_o | output | 7 | One-hot verdict, encoding in R1 |
| tgt_lvl_o | output | 2 | Level a trap is taken to, 0 if none |
| synd_o | output | 8 | Syndrome code for a level-2 trap, else 0 |
| xfer_rd_o | output | 1 | Read data from the chosen copy |
| xfer_wr_o | output | 1 | Write data to the chosen copy |

## Verification
The assertions take the inputs to be known, two-valued levels that settle before they are judged, since they are evaluated combinationally whenever an input moves. They also take no relation between the feature flags for granted: a level-2 enable with no level 2 present, or monitor mode outside level 3, is legal input and must still yield exactly one verdict. The stimulus honours this by driving every input from a single procedural flow, letting it settle before any check, and by sweeping every one of the 2^19 input combinations, including those incoherent ones, besides the directed priority walks.

// File: rtl/perm_pkg.sv
package perm_pkg;

  localparam int NUM_OUTC = 7;

  // Verdict index; the value is also the bit position in the one-hot output.
  typedef enum logic [2:0] {
    OC_UNDEF  = 3'd0,
    OC_TRAP2  = 3'd1,
    OC_TRAP3  = 3'd2,
    OC_VIRT   = 3'd3,
    OC_SINGLE = 3'd4,
    OC_NSEC   = 3'd5,
    OC_SEC    = 3'd6
  } outc_e;

  typedef struct packed {
    logic has2;
    logic has3;
    logic l3_aa32;
    logic lvl2_en;
    logic mon_mode;
    logic cp_trap;
    logic trap_all_g1;
    logic virt_route;
    logic irq_route;
    logic undef_prio;
    logic undef_not_trap;
    logic sre_l1;
    logic sre_l2;
    logic sre_l3;
    logic eff_ns;
  } ctl_t;

endpackage

// File: rtl/perm_lvl1_chain.sv
module perm_lvl1_chain
  import perm_pkg::*;
(
  input  ctl_t  ctl_i,
  output outc_e verdict_o
);
  logic l2_live;
  logic irq_live;

  assign l2_live  = ctl_i.has2 & ctl_i.lvl2_en;
  // Monitor mode under a 32-bit top level masks the IRQ routing checks.
  assign irq_live = ctl_i.has3 & ctl_i.irq_route & ~(ctl_i.l3_aa32 & ctl_i.mon_mode);

  always_comb begin
    if (irq_live && ctl_i.undef_prio)            verdict_o = OC_UNDEF;
    else if (l2_live && ctl_i.cp_trap)           verdict_o = OC_TRAP2;
    else if (!ctl_i.sre_l1)                      verdict_o = OC_UNDEF;
    else if (l2_live && ctl_i.trap_all_g1)       verdict_o = OC_TRAP2;
    else if (l2_live && ctl_i.virt_route)        verdict_o = OC_VIRT;
    else if (irq_live)                           verdict_o = ctl_i.undef_not_trap ? OC_UNDEF : OC_TRAP3;
    else                                         verdict_o = ctl_i.has3 ? OC_NSEC : OC_SINGLE;
  end
endmodule

// File: rtl/perm_lvl2_chain.sv
module perm_lvl2_chain
  import perm_pkg::*;
(
  input  ctl_t  ctl_i,
  output outc_e verdict_o
);
  logic irq_live;

  assign irq_live = ctl_i.has3 & ctl_i.irq_route;

  always_comb begin
    if (irq_live && ctl_i.undef_prio) verdict_o = OC_UNDEF;
    else if (!ctl_i.sre_l2)           verdict_o = OC_UNDEF;
    else if (irq_live)                verdict_o = ctl_i.undef_not_trap ? OC_UNDEF : OC_TRAP3;
    else                              verdict_o = ctl_i.has3 ? OC_NSEC : OC_SINGLE;
  end
endmodule

// File: rtl/perm_lvl3_chain.sv
module perm_lvl3_chain
  import perm_pkg::*;
(
  input  ctl_t  ctl_i,
  output outc_e verdict_o
);
  always_comb begin
    if (!ctl_i.sre_l3)      verdict_o = OC_UNDEF;
    else if (ctl_i.eff_ns)  verdict_o = OC_NSEC;
    else                    verdict_o = OC_SEC;
  end
endmodule

// File: rtl/sysreg_perm_dec.sv
module sysreg_perm_dec
  import perm_pkg::*;
#(
  parameter int          LVL_W      = 2,
  parameter int          SYND_W     = 8,
  parameter logic [7:0]  TRAP2_CODE = 8'h03
) (
  input  logic [LVL_W-1:0]    lvl_i,
  input  logic                mon_mode_i,
  input  logic                gic_present_i,
  input  logic                has_lvl2_i,
  input  logic                has_lvl3_i,
  input  logic                lvl3_aa32_i,
  input  logic                lvl2_en_i,
  input  logic                cp_trap_i,
  input  logic                trap_all_g1_i,
  input  logic                virt_route_i,
  input  logic                irq_route_i,
  input  logic                undef_prio_i,
  input  logic                undef_not_trap_i,
  input  logic                sre_l1_i,
  input  logic                sre_l2_i,
  input  logic                sre_l3_i,
  input  logic                eff_ns_i,
  input  logic                is_write_i,
  output logic [NUM_OUTC-1:0] outcome_o,
  output logic [LVL_W-1:0]    tgt_lvl_o,
  output logic [SYND_W-1:0]   synd_o,
  output logic                xfer_rd_o,
  output logic                xfer_wr_o
);
  localparam logic [LVL_W-1:0] LVL_TWO   = LVL_W'(2);
  localparam logic [LVL_W-1:0] LVL_THREE = LVL_W'(3);

  ctl_t  ctl;
  outc_e v_l1, v_l2, v_l3, sel;
  logic  is_access;

  assign ctl = '{has2: has_lvl2_i, has3: has_lvl3_i, l3_aa32: lvl3_aa32_i,
                 lvl2_en: lvl2_en_i, mon_mode: mon_mode_i, cp_trap: cp_trap_i,
                 trap_all_g1: trap_all_g1_i, virt_route: virt_route_i,
                 irq_route: irq_route_i, undef_prio: undef_prio_i,
                 undef_not_trap: undef_not_trap_i, sre_l1: sre_l1_i,
                 sre_l2: sre_l2_i, sre_l3: sre_l3_i, eff_ns: eff_ns_i};

  perm_lvl1_chain u_l1 (.ctl_i(ctl), .verdict_o(v_l1));
  perm_lvl2_chain u_l2 (.ctl_i(ctl), .verdict_o(v_l2));
  perm_lvl3_chain u_l3 (.ctl_i(ctl), .verdict_o(v_l3));

  always_comb begin
    if (!gic_present_i) sel = OC_UNDEF;
    else begin
      unique case (lvl_i)
        LVL_W'(1): sel = v_l1;
        LVL_TWO:   sel = v_l2;
        LVL_THREE: sel = v_l3;
        default:   sel = OC_UNDEF;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_OUTC; g++) begin : g_onehot
    assign outcome_o[g] = (sel == outc_e'(g));
  end

  always_comb begin
    tgt_lvl_o = '0;
    synd_o    = '0;
    if (sel == OC_TRAP2) begin
      tgt_lvl_o = LVL_TWO;
      synd_o    = SYND_W'(TRAP2_CODE);
    end else if (sel == OC_TRAP3) begin
      tgt_lvl_o = LVL_THREE;
    end
  end

  assign is_access = (sel == OC_VIRT) | (sel == OC_SINGLE) | (sel == OC_NSEC) | (sel == OC_SEC);
  assign xfer_rd_o = is_access & ~is_write_i;
  assign xfer_wr_o = is_access &  is_write_i;

endmodule

// File: rtl/sysreg_perm_dec_chk.sv
module sysreg_perm_dec_chk (
  input logic [1:0] lvl_i,
  input logic       gic_present_i,
  input logic       has_lvl2_i,
  input logic       lvl2_en_i,
  input logic       sre_l3_i,
  input logic       eff_ns_i,
  input logic [6:0] outcome_o,
  input logic [1:0] tgt_lvl_o,
  input logic [7:0] synd_o,
  input logic       xfer_rd_o,
  input logic       xfer_wr_o
);
  always_comb begin
    AST_ONE_VERDICT: assert ($onehot(outcome_o)); // R1
    if (!gic_present_i || lvl_i == 2'd0)
      AST_LOW_LVL_UNDEF: assert (outcome_o[0]); // R2
    if (gic_present_i && lvl_i == 2'd3 && sre_l3_i)
      AST_TOP_BANK_SEL: assert (outcome_o[6] == !eff_ns_i && outcome_o[5] == eff_ns_i); // R6
    if (outcome_o[1])
      AST_L2_TRAP_CODE: assert (tgt_lvl_o == 2'd2 && synd_o == 8'h03); // R7
    if (!outcome_o[1])
      AST_SYND_QUIET: assert (synd_o == 8'h00); // R7
    if (outcome_o[2:0] != 3'b000)
      AST_NO_XFER_FAULT: assert (!xfer_rd_o && !xfer_wr_o); // R8
    AST_XFER_EXCL: assert (!(xfer_rd_o && xfer_wr_o)); // R8
    if (!(has_lvl2_i && lvl2_en_i))
      AST_NO_L2_EFFECT: assert (!outcome_o[1] && !outcome_o[3]); // R9
  end
endmodule

bind sysreg_perm_dec sysreg_perm_dec_chk u_chk (.*);

// File: tb/sysreg_perm_dec_test.sv
module sysreg_perm_dec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [1:0] lvl;
  logic mon, gic, has2, has3, aa32, l2en, cpt, tall, virt, irq, uprio, unt, s1, s2, s3, ens, wr;
  logic [6:0] outc;
  logic [1:0] tgt;
  logic [7:0] synd;
  logic rd_o, wr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sysreg_perm_dec uut (
    .lvl_i(lvl), .mon_mode_i(mon), .gic_present_i(gic), .has_lvl2_i(has2),
    .has_lvl3_i(has3), .lvl3_aa32_i(aa32), .lvl2_en_i(l2en), .cp_trap_i(cpt),
    .trap_all_g1_i(tall), .virt_route_i(virt), .irq_route_i(irq),
    .undef_prio_i(uprio), .undef_not_trap_i(unt), .sre_l1_i(s1), .sre_l2_i(s2),
    .sre_l3_i(s3), .eff_ns_i(ens), .is_write_i(wr), .outcome_o(outc),
    .tgt_lvl_o(tgt), .synd_o(synd), .xfer_rd_o(rd_o), .xfer_wr_o(wr_o)
  );

  localparam logic [6:0] E_UND = 7'b0000001, E_T2 = 7'b0000010, E_T3 = 7'b0000100,
                         E_VIR = 7'b0001000, E_ONE = 7'b0010000, E_NS = 7'b0100000,
                         E_SEC = 7'b1000000;

  // Reference verdict written from the requirement text.
  function automatic logic [6:0] model();
    logic hv, routed, blocked;
    hv      = has2 && l2en;
    blocked = (lvl == 2'd1) && aa32 && mon;
    routed  = has3 && irq && !blocked;
    if (!gic || lvl == 2'd0) return E_UND;
    if (lvl == 2'd3) return !s3 ? E_UND : (ens ? E_NS : E_SEC);
    if (lvl == 2'd2) begin
      if (routed && uprio) return E_UND;
      if (!s2) return E_UND;
      if (routed) return unt ? E_UND : E_T3;
      return has3 ? E_NS : E_ONE;
    end
    if (routed && uprio) return E_UND;
    if (hv && cpt) return E_T2;
    if (!s1) return E_UND;
    if (hv && tall) return E_T2;
    if (hv && virt) return E_VIR;
    if (routed) return unt ? E_UND : E_T3;
    return has3 ? E_NS : E_ONE;
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [1:0] et;
    logic [7:0] es;
    logic acc;
    #1;
    et  = (exp == E_T2) ? 2'd2 : (exp == E_T3) ? 2'd3 : 2'd0;
    es  = (exp == E_T2) ? 8'h03 : 8'h00;
    acc = |exp[6:3];
    checks++;
    if (outc !== exp || tgt !== et || synd !== es || rd_o !== (acc && !wr) || wr_o !== (acc && wr)) begin
      fails++;
      $display("FAIL %s: outc=%b tgt=%0d synd=%h rd=%b wr=%b expected outc=%b tgt=%0d synd=%h rd=%b wr=%b",
               tag, outc, tgt, synd, rd_o, wr_o, exp, et, es, acc && !wr, acc && wr);
    end
  endtask

  // Quiet base: interface present, all enables on, no routing or traps.
  task automatic base(input logic [1:0] l);
    lvl = l; gic = 1; mon = 0; has2 = 1; has3 = 1; aa32 = 0; l2en = 1; cpt = 0; tall = 0;
    virt = 0; irq = 0; uprio = 0; unt = 0; s1 = 1; s2 = 1; s3 = 1; ens = 1; wr = 0;
  endtask

  task automatic t_reset_state();
    {lvl, mon, gic, has2, has3, aa32, l2en, cpt, tall, virt, irq, uprio, unt, s1, s2, s3, ens, wr} = '0;
    check("R2 idle", E_UND);
    check("R1 idle onehot", E_UND);
  endtask

  task automatic t_absent();
    base(2'd1); gic = 0; check("R2 no gic", E_UND);
    base(2'd0); check("R2 level0", E_UND);
    base(2'd3); gic = 0; check("R2 no gic lvl3", E_UND);
  endtask

  task automatic t_lvl1_order();
    base(2'd1); irq = 1; uprio = 1; cpt = 1; s1 = 0; tall = 1; virt = 1;
    check("R3 step1", E_UND);
    uprio = 0; check("R3 step2", E_T2);
    cpt = 0;   check("R3 step3", E_UND);
    s1 = 1;    check("R3 step4", E_T2);
    tall = 0;  check("R3 step5", E_VIR);
    virt = 0;  check("R3 step6", E_T3);
    unt = 1;   check("R3 step6 undef", E_UND);
    irq = 0;   check("R3 ns copy", E_NS);
    has3 = 0;  check("R3 single copy", E_ONE);
  endtask

  task automatic t_monitor();
    base(2'd1); irq = 1; uprio = 1; aa32 = 1; mon = 1;
    check("R4 masked", E_NS);
    aa32 = 0; check("R4 64-bit top", E_UND);
    aa32 = 1; mon = 0; check("R4 not monitor", E_UND);
  endtask

  task automatic t_lvl2();
    base(2'd2); irq = 1; uprio = 1; s2 = 0; cpt = 1; virt = 1;
    check("R5 step1", E_UND);
    uprio = 0; check("R5 step2", E_UND);
    s2 = 1;    check("R5 step3", E_T3);
    unt = 1;   check("R5 step3 undef", E_UND);
    irq = 0;   check("R5 ns copy", E_NS);
    has3 = 0;  check("R5 single copy", E_ONE);
    aa32 = 1; mon = 1; has3 = 1; irq = 1; unt = 0; check("R5 monitor ignored", E_T3);
  endtask

  task automatic t_lvl3();
    base(2'd3); s3 = 0; check("R6 disabled", E_UND);
    s3 = 1; ens = 0; irq = 1; uprio = 1; check("R6 secure", E_SEC);
    ens = 1; check("R6 nonsecure", E_NS);
  endtask

  task automatic t_targets();
    base(2'd1); tall = 1; check("R7 l2 trap", E_T2);
    base(2'd1); irq = 1; check("R7 l3 trap", E_T3);
  endtask

  task automatic t_direction();
    base(2'd3); ens = 0; wr = 1; check("R8 write sec", E_SEC);
    base(2'd1); virt = 1; wr = 1; check("R8 write virt", E_VIR);
    base(2'd1); cpt = 1; wr = 1; check("R8 write trap", E_T2);
  endtask

  task automatic t_gating();
    base(2'd1); l2en = 0; cpt = 1; tall = 1; virt = 1; check("R9 l2 off", E_NS);
    base(2'd1); has2 = 0; cpt = 1; check("R9 no l2", E_NS);
    base(2'd1); has3 = 0; irq = 1; uprio = 1; check("R9 no l3", E_ONE);
    base(2'd2); has3 = 0; irq = 1; check("R9 no l3 lvl2", E_ONE);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < (1 << 19); i++) begin
      logic [18:0] v;
      string tag;
      v = i[18:0];
      {lvl, mon, gic, has2, has3, aa32, l2en, cpt, tall, virt, irq, uprio, unt, s1, s2, s3, ens, wr} = v;
      tag = (!gic || lvl == 0) ? "R2 sweep" : (lvl == 1) ? "R3 sweep" : (lvl == 2) ? "R5 sweep" : "R6 sweep";
      check(tag, model());
    end
  endtask

  initial begin
    t_reset_state();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_absent();
    t_lvl1_order();
    t_monitor();
    t_lvl2();
    t_lvl3();
    t_targets();
    t_direction();
    t_gating();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule